// File: doc/BRIEF.md
# Prioritized Interrupt Status Queue

This block gathers event reports from five producers and hands them to a host through one 16-bit read port. Two producers (receive events and transmit events) may have several reports waiting at once and each owns a small queue; the other three (buffer events, receive-miss counter overflow and transmit-collision counter overflow) own a single report slot. Every returned word carries a 6-bit source identifier in its low bits and 10 bits of report contents above it.

The host keeps reading the same port. Each read returns the highest-priority pending report, and that read removes the report. A read with nothing waiting returns zero, which tells the host it has drained the queue. An interrupt output tells the host that work is waiting. It is gated by a global enable. The first read after it is raised pulls it low, and it stays low until both an empty read has been seen and a minimum low time (1.6 µs, counted in clock cycles from a clock-frequency parameter) has passed.

Top module: `isq_top`

## Requirements
- R1: `rd_data_o[5:0]` holds the source identifier (receive 0x04, transmit 0x08, buffer 0x0C, receive-miss 0x10, transmit-collision 0x12), and `rd_data_o[15:6]` holds that report's 10-bit contents. Source index k on `ev_vld_i[k]` / `ev_data_i[10k+9:10k]` maps to these in the same order, k = 0..4.
- R2: When several sources are pending, the word presented comes from the lowest index pending (receive, transmit, buffer, receive-miss, transmit-collision).
- R3: A clock edge with `rd_i` high removes the presented report, and the next pending report is presented after that edge.
- R4: With nothing pending, `rd_data_o` is 0x0000, and a read then changes nothing.
- R5: The receive and transmit sources each queue up to DEPTH reports and return them oldest first. An event that arrives while its queue is full is ORed into the newest entry.
- R6: Buffer, receive-miss and transmit-collision hold at most one report each. A new event for a pending slot is ORed into it.
- R7: An event that arrives on the same edge as the read that removes its source's presented report stays pending as a new report.
- R8: An event with all-zero contents is ignored.
- R9: `irq_o` rises one cycle after a report is stored, but only while `irq_en_i` is high. It stays high while more events arrive, and it is low in the cycle after any edge where `irq_en_i` is low.
- R10: A read while `irq_o` is high drives it low after that edge. It stays low until an empty read has occurred and HOLD_CYC = ceil(CLK_MHZ*1.6) edges have passed since the dropping read, whichever comes later.
- R11: After that release, `irq_o` returns high on the first edge at which reports are pending and the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_en_i | input | 1 | Global interrupt enable |
| ev_vld_i | input | 5 | Event strobe per source, index = priority |
| ev_data_i | input | 50 | Event contents, 10 bits per source |
| rd_i | input | 1 | Host read strobe, consumes presented report |
| rd_data_o | output | 16 | Presented report: contents and identifier, or zero |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted queue pointer or count shows up at the read port within a few reads, as a report that is duplicated, missing or out of order. A slot that fails to clear shows up on the very next read as a repeated identifier. A broken priority select returns the wrong identifier in the same cycle. Faults in the hold counter or in the record of an empty read show on `irq_o` only at the end of the HOLD_CYC window, so the bench watches every cycle of that window as well as the edge where it closes.

// File: rtl/isq_pkg.sv
package isq_pkg;
  localparam int NSRC = 5;
  localparam int CW   = 10;
  localparam int IDW  = 6;
  localparam int NQ   = 2;  // sources below this index are queued

  function automatic logic [IDW-1:0] src_id(input int idx);
    case (idx)
      0:       return 6'h04;
      1:       return 6'h08;
      2:       return 6'h0C;
      3:       return 6'h10;
      default: return 6'h12;
    endcase
  endfunction
endpackage

// File: rtl/isq_fifo.sv
module isq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         vld_o,
  output logic [W-1:0] data_o
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem_q [DEPTH];
  logic [PW-1:0]   rd_ptr_q, wr_ptr_q, last_ptr;
  logic [CNTW-1:0] cnt_q;
  logic            full, do_pop, merge, do_push;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt_q == CNTW'(DEPTH));
  assign do_pop   = pop_i & (cnt_q != '0);
  assign merge    = push_i & full & ~do_pop;
  assign do_push  = push_i & ~merge;
  assign last_ptr = (wr_ptr_q == '0) ? PW'(DEPTH - 1) : wr_ptr_q - 1'b1;
  assign vld_o    = (cnt_q != '0);
  assign data_o   = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_ptr_q] <= data_i;
        wr_ptr_q        <= inc(wr_ptr_q);
      end else if (merge) begin
        mem_q[last_ptr] <= mem_q[last_ptr] | data_i;
      end
      if (do_pop) rd_ptr_q <= inc(rd_ptr_q);
      cnt_q <= cnt_q + CNTW'(do_push) - CNTW'(do_pop);
    end
  end
endmodule

// File: rtl/isq_slot.sv
module isq_slot #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         clr_i,
  output logic         vld_o,
  output logic [W-1:0] data_o
);
  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= (clr_i ? '0 : val_q) | (push_i ? data_i : '0);
  end

  assign vld_o  = (val_q != '0);
  assign data_o = val_q;
endmodule

// File: rtl/isq_irq.sv
module isq_irq #(
  parameter int HOLD = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pend_i,
  input  logic rd_i,
  output logic irq_o
);
  localparam int CTW = $clog2(HOLD + 1);

  logic [CTW-1:0] cnt_q, cnt_n;
  logic           seen_q, seen_n, blk_q, blk_n, irq_q;
  logic           set, null_rd;

  assign set     = rd_i & irq_q;
  assign null_rd = rd_i & ~pend_i;

  always_comb begin
    cnt_n  = set ? CTW'(HOLD) : ((cnt_q != '0) ? cnt_q - 1'b1 : cnt_q);
    seen_n = set ? null_rd : (seen_q | null_rd);
    // low until both an empty read and the hold time
    blk_n  = set | (blk_q & ~(seen_n & (cnt_n == '0)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      blk_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      seen_q <= seen_n;
      blk_q  <= blk_n;
      irq_q  <= en_i & pend_i & ~blk_n;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/isq_top.sv
module isq_top
  import isq_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int CLK_MHZ = 50
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 irq_en_i,
  input  logic [NSRC-1:0]      ev_vld_i,
  input  logic [NSRC*CW-1:0]   ev_data_i,
  input  logic                 rd_i,
  output logic [CW+IDW-1:0]    rd_data_o,
  output logic                 irq_o
);
  localparam int HOLD_CYC = (CLK_MHZ * 16 + 9) / 10;

  logic [NSRC-1:0] push, pop, pend, sel;
  logic [CW-1:0]   front [NSRC];

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign push[i] = ev_vld_i[i] & (ev_data_i[i*CW +: CW] != '0);
    assign pop[i]  = rd_i & sel[i];
    if (i < NQ) begin : g_q
      isq_fifo #(.DEPTH(DEPTH), .W(CW)) u_fifo (
        .clk_i, .rst_ni,
        .push_i(push[i]), .data_i(ev_data_i[i*CW +: CW]), .pop_i(pop[i]),
        .vld_o(pend[i]), .data_o(front[i])
      );
    end else begin : g_s
      isq_slot #(.W(CW)) u_slot (
        .clk_i, .rst_ni,
        .push_i(push[i]), .data_i(ev_data_i[i*CW +: CW]), .clr_i(pop[i]),
        .vld_o(pend[i]), .data_o(front[i])
      );
    end
  end

  always_comb begin
    logic found;
    found     = 1'b0;
    sel       = '0;
    rd_data_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && !found) begin
        found     = 1'b1;
        sel[i]    = 1'b1;
        rd_data_o = {front[i], src_id(i)};
      end
    end
  end

  isq_irq #(.HOLD(HOLD_CYC)) u_irq (
    .clk_i, .rst_ni,
    .en_i(irq_en_i), .pend_i(|pend), .rd_i(rd_i), .irq_o(irq_o)
  );
endmodule

// File: rtl/isq_chk.sv
module isq_chk #(
  parameter int HOLD = 80
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        irq_en_i,
  input logic        buf_vld_i,
  input logic        rd_i,
  input logic [15:0] rd_data_o,
  input logic        irq_o,
  input logic [4:0]  pend_i
);
  localparam int CTW = $clog2(HOLD + 1);
  logic [CTW-1:0] lowcnt_q;
  logic           dropped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lowcnt_q  <= '0;
      dropped_q <= 1'b0;
    end else if (rd_i && irq_o) begin
      lowcnt_q  <= '0;
      dropped_q <= 1'b1;
    end else if (dropped_q && lowcnt_q < CTW'(HOLD)) begin
      lowcnt_q  <= lowcnt_q + 1'b1;
    end
  end

  AST_ID_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o != 16'h0) |-> ((rd_data_o[5:0] inside {6'h04, 6'h08, 6'h0C, 6'h10, 6'h12})
                              && rd_data_o[15:6] != 10'h0)); // R1
  AST_TX_AFTER_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[5:0] == 6'h08) |-> !pend_i[0]); // R2
  AST_NULL_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o == 16'h0) |-> (pend_i == 5'h0)); // R4
  AST_SLOT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && rd_data_o[5:0] == 6'h0C && !buf_vld_i) |=> (rd_data_o[5:0] != 6'h0C)); // R6
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> !irq_o); // R9
  AST_READ_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && irq_o) |=> !irq_o); // R10
  AST_MIN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dropped_q && !irq_o && lowcnt_q < CTW'(HOLD - 1)) |=> !irq_o); // R10
endmodule

bind isq_top isq_chk #(.HOLD(HOLD_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_en_i(irq_en_i), .buf_vld_i(ev_vld_i[2]),
  .rd_i(rd_i), .rd_data_o(rd_data_o), .irq_o(irq_o), .pend_i(pend)
);

// File: tb/isq_top_tb.sv
module isq_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD_CYC   = 80;  // 50 MHz * 1.6 us

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_en = 1'b0;
  logic [4:0]  ev_vld = '0;
  logic [49:0] ev_data = '0;
  logic        rd = 1'b0;
  logic [15:0] rd_data;
  logic        irq;
  int          checks = 0;
  int          fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  isq_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_en_i(irq_en), .ev_vld_i(ev_vld),
    .ev_data_i(ev_data), .rd_i(rd), .rd_data_o(rd_data), .irq_o(irq)
  );

  typedef struct packed {
    logic [4:0]  v;
    logic [9:0]  cl, ms, bf, tx, rx;
    logic        r;
    logic [15:0] e;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t TBL [NV] = '{
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0000}, // R4 empty read
    '{5'h1F, 10'h010, 10'h008, 10'h004, 10'h002, 10'h001, 1'b0, 16'h0000},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0044}, // R1 R2
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0088}, // R3
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h010C},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0210},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0412},
    '{5'h01, 10'h000, 10'h000, 10'h000, 10'h000, 10'h011, 1'b0, 16'h0000}, // R5 order
    '{5'h01, 10'h000, 10'h000, 10'h000, 10'h000, 10'h022, 1'b0, 16'h0444},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0444},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0884},
    '{5'h02, 10'h000, 10'h000, 10'h000, 10'h001, 10'h000, 1'b0, 16'h0000}, // R5 full merge
    '{5'h02, 10'h000, 10'h000, 10'h000, 10'h002, 10'h000, 1'b0, 16'h0048},
    '{5'h02, 10'h000, 10'h000, 10'h000, 10'h004, 10'h000, 1'b0, 16'h0048},
    '{5'h02, 10'h000, 10'h000, 10'h000, 10'h008, 10'h000, 1'b0, 16'h0048},
    '{5'h02, 10'h000, 10'h000, 10'h000, 10'h100, 10'h000, 1'b0, 16'h0048},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0048},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0088},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0108},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h4208},
    '{5'h04, 10'h000, 10'h000, 10'h001, 10'h000, 10'h000, 1'b0, 16'h0000}, // R6 slot merge
    '{5'h04, 10'h000, 10'h000, 10'h200, 10'h000, 10'h000, 1'b0, 16'h004C},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h804C},
    '{5'h08, 10'h000, 10'h003, 10'h000, 10'h000, 10'h000, 1'b0, 16'h0000}, // R7 slot
    '{5'h08, 10'h000, 10'h004, 10'h000, 10'h000, 10'h000, 1'b1, 16'h00D0},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0110},
    '{5'h01, 10'h000, 10'h000, 10'h000, 10'h000, 10'h005, 1'b0, 16'h0000}, // R7 queue
    '{5'h01, 10'h000, 10'h000, 10'h000, 10'h000, 10'h006, 1'b1, 16'h0144},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0184},
    '{5'h01, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b0, 16'h0000}, // R8 zero event
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0000},
    '{5'h10, 10'h001, 10'h000, 10'h000, 10'h000, 10'h000, 1'b0, 16'h0000}, // R2 late high
    '{5'h01, 10'h000, 10'h000, 10'h000, 10'h000, 10'h001, 1'b0, 16'h0052},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0044},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b1, 16'h0052},
    '{5'h00, 10'h000, 10'h000, 10'h000, 10'h000, 10'h000, 1'b0, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive just after a negedge, return at the next negedge
  task automatic step(input logic [4:0] v, input logic [49:0] d, input logic r);
    ev_vld = v; ev_data = d; rd = r;
    @(negedge clk);
    ev_vld = '0; ev_data = '0; rd = 1'b0;
  endtask

  task automatic idle(); step(5'h0, 50'h0, 1'b0); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic ok;
    repeat (3) @(negedge clk);
    chk("R4 reset data", rd_data, 16'h0000);
    chk("R9 reset irq", {15'h0, irq}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      chk($sformatf("R1-table step %0d data", i), rd_data, TBL[i].e);
      if (irq !== 1'b0) chk("R9 irq while disabled", {15'h0, irq}, 16'h0000);
      step(TBL[i].v, {TBL[i].cl, TBL[i].ms, TBL[i].bf, TBL[i].tx, TBL[i].rx}, TBL[i].r);
    end

    // R9: enable gating
    step(5'h04, 50'h1 << 20, 1'b0);
    idle(); idle();
    chk("R9 disabled stays low", {15'h0, irq}, 16'h0000);
    irq_en = 1'b1;
    idle();
    chk("R9 raised when enabled", {15'h0, irq}, 16'h0001);
    step(5'h02, 50'h1 << 10, 1'b0);
    chk("R9 stays high", {15'h0, irq}, 16'h0001);

    // R10: first read drops; empty read early, hold time governs
    chk("R2 tx before buf", rd_data, 16'h0048);
    step(5'h0, 50'h0, 1'b1);                       // edge n=0
    chk("R10 dropped on read", {15'h0, irq}, 16'h0000);
    chk("R3 next presented", rd_data, 16'h004C);
    step(5'h0, 50'h0, 1'b1);                       // n=1
    step(5'h01, 50'h1, 1'b1);                      // n=2 empty read plus new event
    ok = 1'b1;
    for (int n = 3; n < HOLD_CYC; n++) begin
      idle();
      if (irq !== 1'b0) ok = 1'b0;
    end
    chk("R10 low through hold window", {15'h0, ok}, 16'h0001);
    idle();                                        // n=HOLD_CYC
    chk("R11 raised at end of hold", {15'h0, irq}, 16'h0001);

    // R10: no empty read, hold time long past
    chk("R1 rx word", rd_data, 16'h0044);
    step(5'h0, 50'h0, 1'b1);
    step(5'h10, 50'h1 << 40, 1'b0);
    ok = 1'b1;
    for (int n = 0; n < HOLD_CYC + 5; n++) begin
      idle();
      if (irq !== 1'b0) ok = 1'b0;
    end
    chk("R10 held low without empty read", {15'h0, ok}, 16'h0001);
    chk("R1 col word", rd_data, 16'h0052);
    step(5'h0, 50'h0, 1'b1);
    step(5'h0, 50'h0, 1'b1);                       // empty read releases
    chk("R11 stays low when empty", {15'h0, irq}, 16'h0000);
    step(5'h08, 50'h1 << 30, 1'b0);
    chk("R9 one-cycle lag", {15'h0, irq}, 16'h0000);
    idle();
    chk("R11 raised after release", {15'h0, irq}, 16'h0001);
    irq_en = 1'b0;
    idle();
    chk("R9 disable drops irq", {15'h0, irq}, 16'h0000);
    chk("R6 miss still pending", rd_data, 16'h0050);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule